// File: doc/BRIEF.md
# UART Receiver with Break-Run Tracking

This block recovers asynchronous serial characters from a single receive line. The line first passes through a two-flop synchronizer. It is then sampled on a one-cycle enable that the surrounding logic pulses sixteen times per bit period. The character length (5 to 8 bits), the parity mode and the number of stop positions checked are set by static configuration inputs. These settings must match the transmitter at the far end. Each recovered character is presented right-aligned on a data bus, together with a one-cycle valid strobe. The same strobe cycle carries a parity-error flag and a framing-error flag for that character.

A frame in which every sampled position is low is a break. A break is never delivered as data and never flagged as a framing error. Consecutive break frames form a run. The block pulses one indication when a run begins and one when it ends. A run ends once the line has stayed high for a full bit time. A start bit that is high again at its middle is discarded as noise. After each frame the receiver waits for the line to be high before it looks for the next start bit. This waiting is what lets a line held low produce a single break.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, rx_valid, par_err, frm_err, brk_first and brk_last are 0, rx_data is 0, and no output pulses until a frame is received.
- R2: cfg_len selects the character length as 5 + cfg_len bits (0 means 5, 3 means 8). Data bits arrive least significant first after the start bit. rx_data carries them right-aligned with bits at and above the length forced to 0. rx_valid pulses for one cycle per non-break frame.
- R3: When cfg_par_en is 1, a parity bit follows the data. cfg_par_mode selects the parity mode: 0 is even (the expected bit is 1 when the counted bits are odd in number), 1 is odd (the inverse of even), 2 is mark (expected 1) and 3 is space (expected 0). par_err is 1 in the rx_valid cycle when the received parity bit differs from the expected one. par_err is always 0 when cfg_par_en is 0.
- R4: cfg_par_bias selects which data bits even and odd parity count: 0 counts the ones, 1 counts the zeros.
- R5: frm_err is 1 in the rx_valid cycle of a non-break frame when any checked stop position was sampled low. par_err and frm_err are never 1 outside an rx_valid cycle.
- R6: A frame whose start, data, parity (if enabled) and checked stop positions all sample low is a break. It produces no rx_valid, no frm_err and no par_err. After any frame the receiver ignores the line until it has been seen high.
- R7: brk_first pulses for one cycle on the first break of a run. Further breaks in the same run do not pulse it.
- R8: brk_last pulses for one cycle once the line has been high for 16 consecutive sample enables after a break. A high gap shorter than that between breaks keeps the run going.
- R9: A low level that is high again at the eighth sample enable after the start was seen is discarded, with no output, and the receiver returns to waiting for a start bit.
- R10: cfg_stop2 = 1 checks a second stop position as well as the first. cfg_stop2 = 0 checks only the first, which also covers one-and-a-half stop bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable, 16 pulses per bit |
| rxd | input | 1 | Asynchronous serial receive line, high when idle |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | 0 even, 1 odd, 2 mark, 3 space |
| cfg_par_bias | input | 1 | 0 counts ones, 1 counts zeros |
| cfg_stop2 | input | 1 | Check a second stop position |
| rx_data | output | 8 | Last received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe per received character |
| par_err | output | 1 | Parity mismatch, qualified by rx_valid |
| frm_err | output | 1 | Low stop position, qualified by rx_valid |
| brk_first | output | 1 | First break of a run |
| brk_last | output | 1 | End of a break run |

## Verification
The parity-error and framing-error flags can rise in the same strobe cycle. The bench provokes this with an all-zero character in even mode, sent with a deliberately wrong (high) parity bit and a low stop bit. Because the parity position is high, the frame must not be taken as a break. The scoreboard expects exactly one strobe carrying zero data with both flags set, and no break pulse. Break runs are judged the same way: the queue holds only one first-break and one last-break item per run, so any extra pulse from a run of several frames, or from one long low level, is reported as unexpected.

// File: rtl/uart_rx_brk_pkg.sv
package uart_rx_brk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_HOLD  = 3'd5
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } par_mode_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  // idle level of the line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OSR     = 16,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_stop2,
  output logic              done,
  output logic              brk,
  output logic [DATA_W-1:0] data,
  output logic              par_bit,
  output logic              stop_bad
);

  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;
  localparam int BIT_W = $clog2(DATA_W);

  rx_state_e          st, st_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [BIT_W-1:0]   idx, idx_n;
  logic [DATA_W-1:0]  sh, sh_n;
  logic               pb, pb_n, sbad, sbad_n, zero, zero_n;
  logic               done_q, done_n, brk_q, brk_n, pbo_q, pbo_n, sbado_q, sbado_n;
  logic [DATA_W-1:0]  data_q, data_n;
  logic [BIT_W-1:0]   len_m1;
  logic [BIT_W:0]     shamt;
  logic               bit_end;

  assign len_m1  = BIT_W'(MIN_LEN - 1) + BIT_W'(cfg_len);
  assign shamt   = (BIT_W+1)'(DATA_W - MIN_LEN) - (BIT_W+1)'(cfg_len);
  assign bit_end = tick && (cnt == CNT_W'(OSR - 1));

  always_comb begin
    st_n = st;  cnt_n = cnt;  idx_n = idx;  sh_n = sh;
    pb_n = pb;  sbad_n = sbad;  zero_n = zero;
    done_n = 1'b0;  brk_n = brk_q;  data_n = data_q;
    pbo_n = pbo_q;  sbado_n = sbado_q;
    if (tick && (st == ST_DATA || st == ST_PAR || st == ST_STOP))
      cnt_n = bit_end ? '0 : cnt + 1'b1;
    case (st)
      ST_IDLE: if (tick && !line) begin
        st_n = ST_START;  cnt_n = '0;  idx_n = '0;  sh_n = '0;
        pb_n = 1'b0;  sbad_n = 1'b0;  zero_n = 1'b1;
      end
      ST_START: if (tick) begin
        if (cnt == CNT_W'(HALF - 1)) begin
          cnt_n = '0;
          st_n  = line ? ST_IDLE : ST_DATA;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_DATA: if (bit_end) begin
        sh_n = {line, sh[DATA_W-1:1]};
        if (line) zero_n = 1'b0;
        if (idx == len_m1) begin
          idx_n = '0;
          st_n  = cfg_par_en ? ST_PAR : ST_STOP;
        end else begin
          idx_n = idx + 1'b1;
        end
      end
      ST_PAR: if (bit_end) begin
        pb_n = line;
        if (line) zero_n = 1'b0;
        st_n = ST_STOP;
      end
      ST_STOP: if (bit_end) begin
        sbad_n = sbad | !line;
        zero_n = zero & !line;
        if (cfg_stop2 && idx == '0) begin
          idx_n = 1'b1;
        end else begin
          done_n  = 1'b1;
          brk_n   = zero_n;
          data_n  = sh >> shamt;
          pbo_n   = pb;
          sbado_n = sbad_n;
          st_n    = ST_HOLD;
        end
      end
      ST_HOLD: if (line) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  cnt <= '0;  idx <= '0;  sh <= '0;
      pb <= 1'b0;  sbad <= 1'b0;  zero <= 1'b0;
      done_q <= 1'b0;  brk_q <= 1'b0;  data_q <= '0;
      pbo_q <= 1'b0;  sbado_q <= 1'b0;
    end else begin
      st <= st_n;  cnt <= cnt_n;  idx <= idx_n;  sh <= sh_n;
      pb <= pb_n;  sbad <= sbad_n;  zero <= zero_n;
      done_q <= done_n;  brk_q <= brk_n;  data_q <= data_n;
      pbo_q <= pbo_n;  sbado_q <= sbado_n;
    end
  end

  assign done     = done_q;
  assign brk      = brk_q;
  assign data     = data_q;
  assign par_bit  = pbo_q;
  assign stop_bad = sbado_q;

  // R9: a start level that is high at mid-bit sends the receiver back to idle
  a_r9_glitch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && tick && cnt == CNT_W'(HALF - 1) && line) |=> (st == ST_IDLE && !done_q));

  // R6: after a frame, a low line keeps the receiver from hunting for a start
  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !line) |=> (st == ST_HOLD));

  // R2: bits at and above the configured length are zero on delivery
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !brk_q) |-> ((data_q >> (MIN_LEN + int'(cfg_len))) == '0));

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
  import uart_rx_brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_par_mode,
  input  logic              cfg_par_bias,
  input  logic              par_bit,
  output logic              mismatch
);

  logic len_odd, ones_par, cnt_par, expect_bit;

  // unused upper bits are zero, so reducing the full width is exact
  assign len_odd  = (MIN_LEN % 2 == 1) ^ cfg_len[0];
  assign ones_par = ^data;
  assign cnt_par  = cfg_par_bias ? (ones_par ^ len_odd) : ones_par;

  always_comb begin
    case (par_mode_e'(cfg_par_mode))
      PAR_EVEN:  expect_bit = cnt_par;
      PAR_ODD:   expect_bit = !cnt_par;
      PAR_MARK:  expect_bit = 1'b1;
      default:   expect_bit = 1'b0;
    endcase
  end

  assign mismatch = (par_bit != expect_bit);

endmodule

// File: rtl/uart_rx_brk_track.sv
module uart_rx_brk_track #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic brk_evt,
  output logic brk_first,
  output logic brk_last
);

  localparam int CNT_W = $clog2(OSR);

  logic             in_run, in_run_n, last_q, last_n;
  logic [CNT_W-1:0] hcnt, hcnt_n;

  always_comb begin
    in_run_n = in_run;  hcnt_n = hcnt;  last_n = 1'b0;
    if (brk_evt) begin
      in_run_n = 1'b1;
      hcnt_n   = '0;
    end else if (in_run && tick) begin
      if (!line) begin
        hcnt_n = '0;
      end else if (hcnt == CNT_W'(OSR - 1)) begin
        last_n   = 1'b1;
        in_run_n = 1'b0;
        hcnt_n   = '0;
      end else begin
        hcnt_n = hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run <= 1'b0;  hcnt <= '0;  last_q <= 1'b0;
    end else begin
      in_run <= in_run_n;  hcnt <= hcnt_n;  last_q <= last_n;
    end
  end

  assign brk_first = brk_evt && !in_run;
  assign brk_last  = last_q;

  // R8: the end-of-run pulse only follows an open run
  a_r8_last_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    brk_last |-> $past(in_run));

  // R7: a first-break pulse opens a run
  a_r7_first_opens_run: assert property (@(posedge clk) disable iff (!rst_n)
    brk_first |=> in_run);

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int MIN_LEN     = 5,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_mode,
  input  logic              cfg_par_bias,
  input  logic              cfg_stop2,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk_first,
  output logic              brk_last
);

  logic line_s, fr_done, fr_brk, fr_pb, fr_sbad, mism;
  logic [DATA_W-1:0] fr_data;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2),
    .done(fr_done), .brk(fr_brk), .data(fr_data), .par_bit(fr_pb), .stop_bad(fr_sbad)
  );

  uart_rx_parity #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_par (
    .data(fr_data), .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode),
    .cfg_par_bias(cfg_par_bias), .par_bit(fr_pb), .mismatch(mism)
  );

  uart_rx_brk_track #(.OSR(OSR)) u_trk (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .brk_evt(fr_done && fr_brk), .brk_first(brk_first), .brk_last(brk_last)
  );

  assign rx_data  = fr_data;
  assign rx_valid = fr_done && !fr_brk;
  assign par_err  = rx_valid && cfg_par_en && mism;
  assign frm_err  = rx_valid && fr_sbad;

  // R6: a break never shows up as a character
  a_r6_break_silent: assert property (@(posedge clk) disable iff (!rst_n)
    brk_first |-> (!rx_valid && !frm_err && !par_err));

endmodule

// File: tb/uart_rx_brk_bench.sv
module uart_rx_brk_bench;

  localparam int TDIV   = 4;
  localparam int OSR    = 16;
  localparam int BITCLK = TDIV * OSR;
  localparam int K_CHAR = 0, K_FIRST = 1, K_LAST = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_par_mode = 2'd0;
  logic cfg_par_en = 1'b0, cfg_par_bias = 1'b0, cfg_stop2 = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, par_err, frm_err, brk_first, brk_last;

  int n_chk = 0, n_bad = 0, tdiv_cnt = 0;
  bit running = 1'b0;

  int         q_kind[$];
  logic [7:0] q_data[$];
  logic       q_perr[$], q_ferr[$];
  string      q_req[$];

  uart_rx_brk u_uart_rx_brk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
    .cfg_par_bias(cfg_par_bias), .cfg_stop2(cfg_stop2),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
    .brk_first(brk_first), .brk_last(brk_last)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (tdiv_cnt == TDIV - 1) begin tdiv_cnt <= 0; tick16 <= 1'b1; end
    else begin tdiv_cnt <= tdiv_cnt + 1; tick16 <= 1'b0; end
  end

  function automatic logic exp_par(logic [7:0] d, int len, logic [1:0] mode, logic bias);
    int c = 0;
    for (int i = 0; i < len; i++) if (d[i] != bias) c++;
    case (mode)
      2'd0:    return c[0];
      2'd1:    return !c[0];
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string kind_req(int k);
    if (k == K_CHAR)  return "R2";
    if (k == K_FIRST) return "R7";
    return "R8";
  endfunction

  task automatic expect_item(int k, logic [7:0] d, logic pe, logic fe, string r);
    q_kind.push_back(k); q_data.push_back(d);
    q_perr.push_back(pe); q_ferr.push_back(fe); q_req.push_back(r);
  endtask

  // scoreboard monitor side
  task automatic take(int k);
    int ek; logic [7:0] ed; logic ep, ef; string er;
    n_chk++;
    if (q_kind.size() == 0) begin
      n_bad++;
      $display("FAIL %s unexpected event kind=%0d expected none", kind_req(k), k);
    end else begin
      ek = q_kind.pop_front(); ed = q_data.pop_front();
      ep = q_perr.pop_front(); ef = q_ferr.pop_front(); er = q_req.pop_front();
      if (ek != k) begin
        n_bad++;
        $display("FAIL %s event kind actual=%0d expected=%0d", er, k, ek);
      end else if (k == K_CHAR && (rx_data !== ed || par_err !== ep || frm_err !== ef)) begin
        n_bad++;
        $display("FAIL %s char actual data=%02h perr=%0b ferr=%0b expected data=%02h perr=%0b ferr=%0b",
                 er, rx_data, par_err, frm_err, ed, ep, ef);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      if (rx_valid)  take(K_CHAR);
      if (brk_first) take(K_FIRST);
      if (brk_last)  take(K_LAST);
      if ((par_err || frm_err) && !rx_valid) begin
        n_chk++; n_bad++;
        $display("FAIL R5 flag without strobe actual par=%0b frm=%0b expected 0 0", par_err, frm_err);
      end
    end
  end

  task automatic drive_bit(logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic set_cfg(logic [1:0] len, logic pe, logic [1:0] mode, logic bias, logic s2);
    cfg_len = len; cfg_par_en = pe; cfg_par_mode = mode; cfg_par_bias = bias; cfg_stop2 = s2;
    repeat (4) @(negedge clk);
  endtask

  // driver side: push the expected item, then drive the frame
  task automatic send_frame(logic [7:0] d, logic bad_par, logic [1:0] zstop, string r);
    int len; logic p, fe; logic [7:0] m;
    len = 5 + int'(cfg_len);
    m   = 8'((9'h1 << len) - 9'h1) & d;
    p   = exp_par(d, len, cfg_par_mode, cfg_par_bias) ^ bad_par;
    fe  = zstop[0] | (cfg_stop2 & zstop[1]);
    expect_item(K_CHAR, m, cfg_par_en & bad_par, fe, r);
    drive_bit(1'b0);
    for (int i = 0; i < len; i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit(p);
    drive_bit(!zstop[0]);
    if (cfg_stop2) drive_bit(!zstop[1]);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  // R7 / R8: a run of n break frames separated by short high gaps
  task automatic send_breaks(int n);
    int nbits;
    nbits = 1 + 5 + int'(cfg_len) + int'(cfg_par_en) + 1 + int'(cfg_stop2);
    expect_item(K_FIRST, 8'h00, 1'b0, 1'b0, "R7");
    expect_item(K_LAST,  8'h00, 1'b0, 1'b0, "R8");
    for (int k = 0; k < n; k++) begin
      rxd = 1'b0;
      repeat (nbits * BITCLK) @(negedge clk);
      rxd = 1'b1;
      if (k < n - 1) repeat (4 * TDIV) @(negedge clk);
    end
    repeat (3 * BITCLK) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rx_valid !== 1'b0 || par_err !== 1'b0 || frm_err !== 1'b0 ||
        brk_first !== 1'b0 || brk_last !== 1'b0 || rx_data !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual v=%0b pe=%0b fe=%0b bf=%0b bl=%0b d=%02h expected all 0",
               rx_valid, par_err, frm_err, brk_first, brk_last, rx_data);
    end
    running = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);

    // R2: lengths and right alignment
    set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
    send_frame(8'hA5, 1'b0, 2'b00, "R2");
    send_frame(8'h3C, 1'b0, 2'b00, "R2");
    send_frame(8'h00, 1'b0, 2'b00, "R6");   // all-zero data with high stop is a character
    send_frame(8'hFF, 1'b0, 2'b00, "R2");
    set_cfg(2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    send_frame(8'hEA, 1'b0, 2'b00, "R2");
    set_cfg(2'd1, 1'b0, 2'd0, 1'b0, 1'b0);
    send_frame(8'hC7, 1'b0, 2'b00, "R2");
    set_cfg(2'd2, 1'b0, 2'd0, 1'b0, 1'b0);
    send_frame(8'hD9, 1'b0, 2'b00, "R2");

    // R3: parity modes
    set_cfg(2'd3, 1'b1, 2'd0, 1'b0, 1'b0);
    send_frame(8'h5A, 1'b0, 2'b00, "R3");
    send_frame(8'h5B, 1'b1, 2'b00, "R3");
    set_cfg(2'd2, 1'b1, 2'd1, 1'b0, 1'b0);
    send_frame(8'h33, 1'b0, 2'b00, "R3");
    send_frame(8'h33, 1'b1, 2'b00, "R3");
    set_cfg(2'd3, 1'b1, 2'd2, 1'b0, 1'b0);
    send_frame(8'h81, 1'b0, 2'b00, "R3");
    send_frame(8'h81, 1'b1, 2'b00, "R3");
    set_cfg(2'd1, 1'b1, 2'd3, 1'b0, 1'b0);
    send_frame(8'h2A, 1'b0, 2'b00, "R3");
    send_frame(8'h2A, 1'b1, 2'b00, "R3");

    // R4: zero-count bias
    set_cfg(2'd2, 1'b1, 2'd0, 1'b1, 1'b0);
    send_frame(8'h0F, 1'b0, 2'b00, "R4");
    send_frame(8'h0F, 1'b1, 2'b00, "R4");
    set_cfg(2'd0, 1'b1, 2'd1, 1'b1, 1'b0);
    send_frame(8'h13, 1'b0, 2'b00, "R4");

    // R5: framing error
    set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
    send_frame(8'h33, 1'b0, 2'b01, "R5");

    // R10: second stop position
    set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b1);
    send_frame(8'h44, 1'b0, 2'b00, "R10");
    send_frame(8'h44, 1'b0, 2'b10, "R10");
    send_frame(8'h44, 1'b0, 2'b01, "R10");

    // R5 with R3: both flags in one strobe, zero data that is not a break
    set_cfg(2'd3, 1'b1, 2'd0, 1'b0, 1'b0);
    send_frame(8'h00, 1'b1, 2'b01, "R5");

    // R6 / R7 / R8: break runs
    set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
    send_breaks(1);
    set_cfg(2'd3, 1'b1, 2'd0, 1'b0, 1'b1);
    send_breaks(3);
    set_cfg(2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    expect_item(K_FIRST, 8'h00, 1'b0, 1'b0, "R6");
    expect_item(K_LAST,  8'h00, 1'b0, 1'b0, "R8");
    rxd = 1'b0;
    repeat (40 * BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    send_frame(8'h1B, 1'b0, 2'b00, "R6");

    // R9: short glitch then a character
    set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    send_frame(8'h96, 1'b0, 2'b00, "R9");

    repeat (4 * BITCLK) @(negedge clk);
    running = 1'b0;
    n_chk++;
    if (q_kind.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing events actual pending=%0d expected 0", q_kind.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule